// File: doc/BRIEF.md
# Single-Precision Rounding Back End

This block is the last stage of a floating-point datapath. An arithmetic unit upstream produces an unrounded result. That result is a sign, a signed unbiased exponent and a 24-bit significand with its leading one in the top bit. Three extra bits sit below the significand: guard, round and sticky. The block rounds this value to single precision and packs it into a 32-bit word. It also reports overflow, underflow and inexact.

A two-bit mode input picks the rounding direction. When the exponent is below the normal range, the significand is shifted into denormal position before rounding. Bits shifted out fold into sticky. When rounding carries out of the significand, the exponent increases by one. On overflow, the result is either infinity or the largest finite magnitude, depending on the mode and the sign. Tininess is judged after rounding, as if the exponent range had no lower limit. Underflow is raised only when the result is both tiny and inexact.

The block has one register stage. A result and its flags appear on the cycle after the matching `valid_i`.

Top module: `fp_round_unit`

## Requirements
- R1: Mode encoding is 00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity. In mode 00, the nearer value is delivered, and an exact halfway case goes to the value whose fraction LSB is 0.
- R2: The directed modes behave as follows. Mode 01 always truncates. Mode 10 rounds a negative result's magnitude up when any discarded bit is set. Mode 11 does the same for a positive result.
- R3: The result word is laid out as sign in bit 31, exponent in bits 30:23 biased by 127, and fraction in bits 22:0. A value with unbiased exponent E from -126 to 127 is packed with biased exponent E+127. No output has exponent 255 with a nonzero fraction.
- R4: Suppose rounding a normal result carries out of the 24-bit significand. Then the output has fraction 0 and biased exponent one higher, and this can itself cause overflow.
- R5: Suppose the unbiased exponent is below -126. Then the value is packed as a denormal with biased exponent 0, rounded at the 2^-149 position. A denormal that rounds up to 2^-126 is packed with biased exponent 1 and fraction 0.
- R6: Overflow means a rounded biased exponent of 255 or more. The result is infinity (exponent 255, fraction 0) in mode 00, in mode 11 for a positive sign, and in mode 10 for a negative sign. Otherwise the result is the largest finite magnitude (exponent 254, fraction all ones). The sign is always the input sign.
- R7: `inexact_o` is set when the packed value differs from the exact input value, and on every overflow.
- R8: `underflow_o` is set only when the result is inexact and also tiny. Tiny means that rounding to 24 bits with an unbounded exponent gives a magnitude below 2^-126.
- R9: A significand of 0 is treated as an exact zero. The output is the input sign with all other bits 0, and no flag is raised.
- R10: `valid_o` is 1 exactly one cycle after `valid_i` was 1, and it is 0 after reset. Result and flags are registered together with `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input value is present this cycle |
| sign_i | input | 1 | Sign of the unrounded result |
| exp_i | input | EXP_W (10) | Signed unbiased exponent of the leading significand bit |
| sig_i | input | 24 | Significand; bit 23 is the leading one, or all zero for an exact zero |
| grs_i | input | 3 | Guard, round, sticky (bit 2 down to bit 0) |
| mode_i | input | 2 | Rounding direction, encoded as in R1 |
| valid_o | output | 1 | Result present |
| result_o | output | 32 | Packed single-precision word |
| overflow_o | output | 1 | Overflow flag |
| underflow_o | output | 1 | Underflow flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The embedded properties check these relations on every cycle:
- the one-cycle valid timing;
- inexact always accompanying overflow or underflow;
- an overflowed word always having one of the two allowed magnitudes;
- no NaN pattern ever being produced;
- a zero significand giving a clean signed zero with no flags.

Some cases can only be shown by the bench's scenarios, which compare against an integer model of the rounding rules. These are:
- which of the two overflow magnitudes each mode and sign pair selects;
- tie-to-even choices;
- binade carries;
- the denormal that rounds into the smallest normal without underflow;
- the exact denormal that must not raise underflow.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;
  localparam int MAN_W  = 24;
  localparam int FRAC_W = MAN_W - 1;
  localparam int EXPF_W = 8;
  localparam int BIAS   = 127;
  localparam int EMAX_B = 254;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_DOWN = 2'b10,
    RM_UP   = 2'b11
  } rmode_e;
endpackage

// File: rtl/fp_denorm_align.sv
module fp_denorm_align
  import fp_round_pkg::*;
#(
  parameter int BW = 12
) (
  input  logic signed [BW-1:0] be_i,
  input  logic [MAN_W-1:0]     sig_i,
  input  logic [2:0]           grs_i,
  output logic [MAN_W-1:0]     mant_o,
  output logic                 guard_o,
  output logic                 sticky_o
);
  localparam int EXT_W = MAN_W + 3;
  localparam int SH_W  = $clog2(EXT_W + 1);

  logic signed [BW-1:0] diff;
  logic [SH_W-1:0]      sh;
  logic [EXT_W-1:0]     ext, shifted, lost_mask;

  always_comb begin
    diff = $signed(BW'(1)) - be_i;
    if (be_i > $signed(BW'(0)))              sh = '0;
    else if (diff > $signed(BW'(EXT_W)))     sh = SH_W'(EXT_W);
    else                                     sh = diff[SH_W-1:0];
    ext       = {sig_i, grs_i};
    shifted   = ext >> sh;
    lost_mask = ~({EXT_W{1'b1}} << sh);
    mant_o    = shifted[EXT_W-1:3];
    guard_o   = shifted[2];
    sticky_o  = (|shifted[1:0]) | (|(ext & lost_mask));
  end
endmodule

// File: rtl/fp_round_decide.sv
module fp_round_decide
  import fp_round_pkg::*;
(
  input  rmode_e mode_i,
  input  logic   sign_i,
  input  logic   lsb_i,
  input  logic   guard_i,
  input  logic   sticky_i,
  output logic   inc_o
);
  always_comb begin
    unique case (mode_i)
      RM_NEAR: inc_o = guard_i & (sticky_i | lsb_i);
      RM_ZERO: inc_o = 1'b0;
      RM_DOWN: inc_o = sign_i & (guard_i | sticky_i);
      RM_UP:   inc_o = ~sign_i & (guard_i | sticky_i);
      default: inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack
  import fp_round_pkg::*;
#(
  parameter int BW = 12
) (
  input  logic                 sign_i,
  input  rmode_e               mode_i,
  input  logic signed [BW-1:0] be_i,
  input  logic                 is_den_i,
  input  logic [MAN_W:0]       rounded_i,
  output logic [31:0]          word_o,
  output logic                 ovf_o
);
  logic signed [BW-1:0] be_f;
  logic                 to_inf;

  always_comb begin
    if (is_den_i) be_f = $signed({{(BW-1){1'b0}}, rounded_i[MAN_W-1]});
    else          be_f = be_i + $signed({{(BW-1){1'b0}}, rounded_i[MAN_W]});
    ovf_o  = be_f > $signed(BW'(EMAX_B));
    to_inf = (mode_i == RM_NEAR) || (mode_i == RM_DOWN && sign_i) ||
             (mode_i == RM_UP && !sign_i);
    if (!ovf_o)      word_o = {sign_i, be_f[EXPF_W-1:0], rounded_i[FRAC_W-1:0]};
    else if (to_inf) word_o = {sign_i, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
    else             word_o = {sign_i, EXPF_W'(EMAX_B), {FRAC_W{1'b1}}};
  end
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fp_round_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0]        sig_i,
  input  logic [2:0]              grs_i,
  input  logic [1:0]              mode_i,
  output logic                    valid_o,
  output logic [31:0]             result_o,
  output logic                    overflow_o,
  output logic                    underflow_o,
  output logic                    inexact_o
);
  localparam int BW = EXP_W + 2;

  rmode_e               mode;
  logic signed [BW-1:0] be;
  logic                 is_den, is_zero;
  logic [MAN_W-1:0]     mant;
  logic                 guard, sticky, inc, inc_wide, tiny, ovf, lossy;
  logic [MAN_W:0]       rounded;
  logic [31:0]          word, word_c;
  logic                 ovf_c, uf_c, inx_c;

  assign mode    = rmode_e'(mode_i);
  assign be      = BW'(exp_i) + $signed(BW'(BIAS));
  assign is_den  = be < $signed(BW'(1));
  assign is_zero = (sig_i == '0);

  fp_denorm_align #(.BW(BW)) u_align (
    .be_i(be), .sig_i(sig_i), .grs_i(grs_i),
    .mant_o(mant), .guard_o(guard), .sticky_o(sticky)
  );

  fp_round_decide u_dec (
    .mode_i(mode), .sign_i(sign_i), .lsb_i(mant[0]),
    .guard_i(guard), .sticky_i(sticky), .inc_o(inc)
  );

  // 24-bit rounding at unbounded exponent, used only for tininess
  fp_round_decide u_dec_wide (
    .mode_i(mode), .sign_i(sign_i), .lsb_i(sig_i[0]),
    .guard_i(grs_i[2]), .sticky_i(|grs_i[1:0]), .inc_o(inc_wide)
  );

  assign rounded = {1'b0, mant} + {{MAN_W{1'b0}}, inc};
  assign lossy   = guard | sticky;
  assign tiny    = is_den && !(be == '0 && (&sig_i) && inc_wide);

  fp_round_pack #(.BW(BW)) u_pack (
    .sign_i(sign_i), .mode_i(mode), .be_i(be), .is_den_i(is_den),
    .rounded_i(rounded), .word_o(word), .ovf_o(ovf)
  );

  always_comb begin
    if (is_zero) begin
      word_c = {sign_i, 31'b0};
      ovf_c  = 1'b0;
      uf_c   = 1'b0;
      inx_c  = 1'b0;
    end else begin
      word_c = word;
      ovf_c  = ovf;
      uf_c   = tiny & lossy;
      inx_c  = lossy | ovf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      inexact_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o    <= word_c;
        overflow_o  <= ovf_c;
        underflow_o <= uf_c;
        inexact_o   <= inx_c;
      end
    end
  end

  p_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_ovf_inexact_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && overflow_o) |-> inexact_o);
  p_uf_tiny_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && underflow_o) |-> (inexact_o && !overflow_o && result_o[30:24] == 7'd0));
  p_ovf_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && overflow_o) |-> (result_o[30:24] == 7'h7F &&
      (result_o[23] ? result_o[22:0] == 23'd0 : (&result_o[22:0]))));
  p_no_nan_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(result_o[30:23] == 8'hFF && result_o[22:0] != 23'd0));
  p_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(sig_i == '0)) |->
      (result_o[30:0] == 31'd0 && !overflow_o && !underflow_o && !inexact_o));
endmodule

// File: tb/sim_fp_round_unit.sv
`timescale 1ns/1ps
module sim_fp_round_unit;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid_i = 1'b0;
  logic              sign_i = 1'b0;
  logic signed [9:0] exp_i = '0;
  logic [23:0]       sig_i = '0;
  logic [2:0]        grs_i = '0;
  logic [1:0]        mode_i = '0;
  logic              valid_o, overflow_o, underflow_o, inexact_o;
  logic [31:0]       result_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [34:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  fp_round_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sign_i(sign_i),
    .exp_i(exp_i), .sig_i(sig_i), .grs_i(grs_i), .mode_i(mode_i),
    .valid_o(valid_o), .result_o(result_o), .overflow_o(overflow_o),
    .underflow_o(underflow_o), .inexact_o(inexact_o)
  );

  function automatic bit rnd_up(int md, bit s, bit odd, longint rem, longint half);
    case (md)
      0: return (rem > half) || (rem == half && odd);
      1: return 1'b0;
      2: return s && rem != 0;
      default: return !s && rem != 0;
    endcase
  endfunction

  // returns {overflow, underflow, inexact, word}
  function automatic logic [34:0] model(bit s, int e, int sigv, int grs, int md);
    longint x, q, rem, half, m, q3, m3;
    int k, eb, frac;
    bit inx, tiny, to_inf;
    if (sigv == 0) return {3'b000, s, 31'd0};
    x = (longint'(sigv) << 3) | longint'(grs);
    k = (e >= -126) ? 3 : (-123 - e);
    if (k > 40) k = 40;
    q    = x >> k;
    rem  = x - (q << k);
    half = longint'(1) << (k - 1);
    inx  = (rem != 0);
    m    = q + longint'(rnd_up(md, s, q[0], rem, half));
    if (e >= -126) begin
      if (m == (longint'(1) << 24)) begin m = longint'(1) << 23; e = e + 1; end
      eb   = e + 127;
      frac = int'(m) - (1 << 23);
      tiny = 0;
    end else begin
      eb   = (m == (longint'(1) << 23)) ? 1 : 0;
      frac = int'(m) & 32'h7FFFFF;
      q3   = x >> 3;
      m3   = q3 + longint'(rnd_up(md, s, q3[0], x - (q3 << 3), 4));
      tiny = !(e == -127 && m3 == (longint'(1) << 24));
    end
    if (eb >= 255) begin
      to_inf = (md == 0) || (md == 2 && s) || (md == 3 && !s);
      if (to_inf) return {3'b101, s, 8'hFF, 23'd0};
      return {3'b101, s, 8'hFE, 23'h7FFFFF};
    end
    return {1'b0, tiny && inx, inx, s, 8'(eb), 23'(frac)};
  endfunction

  task automatic send(bit s, int e, int sigv, int grs, int md, string tag);
    @(negedge clk);
    valid_i = 1'b1; sign_i = s; exp_i = 10'(e); sig_i = 24'(sigv);
    grs_i = 3'(grs); mode_i = 2'(md);
    exp_q.push_back(model(s, e, sigv, grs, md));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      logic [34:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected valid_o: actual 1 expected 0");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({overflow_o, underflow_o, inexact_o, result_o} !== e) begin
          fails++;
          $display("FAIL %s: actual ovf%0b uf%0b inx%0b %h expected ovf%0b uf%0b inx%0b %h",
                   t, overflow_o, underflow_o, inexact_o, result_o,
                   e[34], e[33], e[32], e[31:0]);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || result_o !== 32'd0) begin
      fails++;
      $display("FAIL R10 reset state: actual %b %h expected 0 00000000", valid_o, result_o);
    end
    rst_n = 1'b1;
    // R9 signed zero, all modes
    for (int md = 0; md < 4; md++) send(1, 5, 0, 0, md, "R9 zero");
    send(0, -200, 0, 0, 0, "R9 zero pos");
    // R3 exact normals and range ends
    send(0, 0, 24'h800000, 0, 0, "R3 one");
    send(1, 127, 24'hABCDEF, 0, 1, "R3 top exp");
    send(0, -126, 24'h800001, 0, 2, "R3 min normal");
    // R1 nearest ties
    send(0, 0, 24'h800000, 3'b100, 0, "R1 tie even");
    send(0, 0, 24'h800001, 3'b100, 0, "R1 tie odd");
    send(1, 3, 24'h912345, 3'b101, 0, "R1 above half");
    send(0, 3, 24'h912345, 3'b011, 0, "R1 below half");
    // R2 directed
    for (int md = 1; md < 4; md++) begin
      send(0, 0, 24'h800000, 3'b001, md, "R2 pos sticky");
      send(1, 0, 24'h800000, 3'b001, md, "R2 neg sticky");
    end
    // R4 binade carry
    send(0, 0, 24'hFFFFFF, 3'b100, 0, "R4 carry");
    send(1, 20, 24'hFFFFFF, 3'b001, 2, "R4 carry down");
    send(0, 127, 24'hFFFFFF, 3'b110, 0, "R4 carry to overflow");
    // R6 overflow per mode and sign
    for (int md = 0; md < 4; md++) begin
      send(0, 128, 24'h800000, 0, md, "R6 pos ovf");
      send(1, 128, 24'h800000, 0, md, "R6 neg ovf");
    end
    send(1, 300, 24'hC00000, 3'b111, 1, "R6 far ovf");
    // R5 denormals
    send(0, -127, 24'h800000, 0, 0, "R5 exact denorm");
    send(0, -149, 24'h800000, 0, 0, "R5 min denorm");
    send(0, -150, 24'h800000, 0, 0, "R5 tie to zero");
    send(0, -150, 24'h800000, 0, 3, "R5 up to min denorm");
    send(1, -170, 24'h812345, 3'b010, 2, "R5 deep neg down");
    send(0, -127, 24'hFFFFFF, 3'b100, 0, "R5 round to min normal");
    // R8 tininess after rounding
    send(0, -127, 24'hFFFFFE, 3'b100, 0, "R8 tiny inexact");
    send(0, -127, 24'hFFFFFF, 3'b000, 1, "R8 tiny truncated");
    send(1, -127, 24'hFFFFFF, 3'b001, 2, "R8 not tiny");
    // R7 inexact only with lost bits
    send(0, 10, 24'hF00001, 3'b000, 3, "R7 exact");
    send(1, 10, 24'hF00001, 3'b010, 1, "R7 lost bits");
    // R10 gaps
    idle(); idle();
    send(0, 1, 24'h900000, 0, 0, "R10 after gap");
    idle();
    for (int i = 0; i < 3000; i++) begin
      int e, sg, g, md;
      bit s;
      s  = 1'($urandom);
      e  = int'($urandom_range(0, 320)) - 170;
      sg = int'({1'b1, 23'($urandom)});
      if ($urandom_range(0, 9) == 0) sg = 24'hFFFFFF;
      if ($urandom_range(0, 19) == 0) sg = 0;
      g  = int'($urandom_range(0, 7));
      md = int'($urandom_range(0, 3));
      send(s, e, (sg == 0) ? 0 : sg, (sg == 0) ? 0 : g, md, "R1 R2 R5 R6 R8 random");
      if ($urandom_range(0, 15) == 0) idle();
    end
    idle(); idle(); idle();
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing results: actual %0d pending expected 0", exp_q.size());
    end
    summary();
  end
endmodule